// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block raises a periodic interrupt from a two-stage divider. A prescaler stage divides the processor clock by a programmable amount held in an 8-bit scale register. Each time the prescaler expires it issues one tick. The tick steps a 16-bit down-counter. When a tick arrives while the counter stands at zero, the block issues an interrupt pulse and reloads the counter from a 16-bit period register.

Software programs the block through a small register port with one word-wide write and a combinational read. It can write the counter directly to set the length of the first interval; every later interval takes its length from the period register. An enable input freezes both stages, so counting resumes from the same state when the enable returns.

Top module: `ivt_timer`

## Requirements
- R1: After reset the counter, period and scale registers all read zero and `irq` is low.
- R2: The register select `addr` maps 0 to the counter, 1 to the period and 2 to the scale; the scale occupies bits 7:0 and its upper read bits are zero; select 3 reads zero. A write takes effect at the clock edge where `wr_en` is high.
- R3: With scale value s, the prescaler issues a tick once every s+1 enabled cycles, so a scale of 0 ticks on every enabled cycle. After reset the first enabled cycle ticks.
- R4: A tick that finds the counter non-zero decrements it by one.
- R5: A tick that finds the counter at zero reloads it from the period register and makes `irq` high for exactly the one cycle after that clock edge.
- R6: After the counter is written with c, the first expiry falls on the (c+1)-th tick, and each later expiry falls p+1 ticks after the previous one, where p is the period value.
- R7: A period of zero makes every tick after the first expiry an expiry, so `irq` is high on every tick.
- R8: While `en` is low, the counter and the prescaler hold their values and `irq` stays low. When `en` returns, counting continues from the held state.
- R9: A counter write in the same cycle as a tick takes priority: the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timer run enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt pulse, one cycle per expiry |

## Verification
A register write is visible on `rdata` in the cycle that follows its clock edge. With the first enabled edge numbered zero, the counter reflects a tick taken at edge e right after edge e. The interrupt for an expiry at edge e is high during the cycle between edge e and edge e+1. The bench samples every output at the falling edge. It numbers the enabled rising edges from the moment it raises `en`, and it derives the expected interrupt edges from the formula c(s+1) + k(p+1)(s+1). This lets every cycle of every swept configuration be compared against an exact arithmetic prediction.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   localparam int unsigned SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_COUNT  = 2'd0,
      SEL_PERIOD = 2'd1,
      SEL_SCALE  = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
   parameter int unsigned SCL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SCL_W-1:0] scale,
   output logic             tick
);
   generate
      if (SCL_W < 1) begin : g_bad_width
         $error("ivt_prescaler: SCL_W must be at least 1");
      end
   endgenerate

   logic [SCL_W-1:0] remain;

   assign tick = run && (remain == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (run) begin
         if (remain == '0) remain <= scale;
         else              remain <= remain - 1'b1;
      end
   end

   AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(remain)); // R8
   AST_PSC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> remain == $past(scale)); // R3
endmodule

// File: rtl/ivt_downcounter.sv
module ivt_downcounter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ivt_downcounter: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ZERO = '0;

   assign expire = tick && (count == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= ZERO;
      end else if (load) begin
         count <= load_val;
      end else if (tick) begin
         if (count == ZERO) count <= period;
         else               count <= count - 1'b1;
      end
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count)); // R8
   AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count != ZERO) |=> count == $past(count) - 1'b1); // R4
   AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count == ZERO) |=> count == $past(period)); // R5
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val)); // R9
endmodule

// File: rtl/ivt_cfg_regs.sv
module ivt_cfg_regs #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned SCL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_period,
   input  logic             wr_scale,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] period,
   output logic [SCL_W-1:0] scale
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period <= '0;
         scale  <= '0;
      end else begin
         if (wr_period) period <= wdata;
         if (wr_scale)  scale  <= wdata[SCL_W-1:0];
      end
   end

   AST_PERIOD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_period |=> period == $past(wdata)); // R2
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned SCL_W     = 8,
   parameter bit          IRQ_FLOP  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic                       wr_en,
   input  logic [ivt_pkg::SEL_W-1:0]  addr,
   input  logic [CNT_W-1:0]           wdata,
   output logic [CNT_W-1:0]           rdata,
   output logic                       irq
);
   import ivt_pkg::*;

   generate
      if (SCL_W > CNT_W) begin : g_bad_ratio
         $error("ivt_timer: SCL_W must not exceed CNT_W");
      end
   endgenerate

   localparam int unsigned PAD_W = CNT_W - SCL_W;

   reg_sel_e         sel;
   logic             tick, expire;
   logic             wr_count, wr_period, wr_scale;
   logic [CNT_W-1:0] count, period;
   logic [SCL_W-1:0] scale;

   assign sel       = reg_sel_e'(addr);
   assign wr_count  = wr_en && (sel == SEL_COUNT);
   assign wr_period = wr_en && (sel == SEL_PERIOD);
   assign wr_scale  = wr_en && (sel == SEL_SCALE);

   ivt_cfg_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_period(wr_period), .wr_scale(wr_scale),
      .wdata(wdata), .period(period), .scale(scale));

   ivt_prescaler #(.SCL_W(SCL_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(en), .scale(scale), .tick(tick));

   ivt_downcounter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_count),
      .load_val(wdata), .period(period), .count(count), .expire(expire));

   always_comb begin
      unique case (sel)
         SEL_COUNT:  rdata = count;
         SEL_PERIOD: rdata = period;
         SEL_SCALE:  rdata = {{PAD_W{1'b0}}, scale};
         default:    rdata = '0;
      endcase
   end

   generate
      if (IRQ_FLOP) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= expire;
         end
         assign irq = irq_q;

         AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq) |-> $past(expire)); // R5
         AST_IRQ_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> !irq); // R8
      end else begin : g_irq_comb
         assign irq = expire;
      end
   endgenerate
endmodule

// File: tb/tb_ivt_timer.sv
`timescale 1ns/1ps
module tb_ivt_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ivt_timer dut (
      .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      en = 1'b0; wr_en = 1'b0; rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      addr = a;
      #0.5;
      v = rdata;
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v;
      do_reset();
      // R1 reset state
      rd(2'd0, v); chk(v == 0, "R1 count", v, 0);
      rd(2'd1, v); chk(v == 0, "R1 period", v, 0);
      rd(2'd2, v); chk(v == 0, "R1 scale", v, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);

      // R2 register map
      wr(2'd2, 16'h01AB);
      rd(2'd2, v); chk(v == 16'h00AB, "R2 scale low byte", v, 16'h00AB);
      wr(2'd1, 16'hBEEF);
      rd(2'd1, v); chk(v == 16'hBEEF, "R2 period", v, 16'hBEEF);
      wr(2'd0, 16'h1234);
      rd(2'd0, v); chk(v == 16'h1234, "R2 count", v, 16'h1234);
      wr(2'd3, 16'hFFFF);
      rd(2'd3, v); chk(v == 0, "R2 unused select", v, 0);
      rd(2'd1, v); chk(v == 16'hBEEF, "R2 unused select no side effect", v, 16'hBEEF);

      // R3 R5 R6 R7 sweep: irq on every cycle
      for (int s = 0; s < 4; s++) begin
         for (int ci = 0; ci < 3; ci++) begin
            for (int pi = 0; pi < 3; pi++) begin
               int c, p, first, gap, n, bad, ba, be, hits;
               c = (ci == 0) ? 0 : (ci == 1) ? 1 : 3;
               p = (pi == 0) ? 0 : (pi == 1) ? 2 : 5;
               first = c * (s + 1);
               gap = (p + 1) * (s + 1);
               n = first + 2 * gap + 1;
               bad = 0; ba = 0; be = 0; hits = 0;
               do_reset();
               wr(2'd2, 16'(s));
               wr(2'd1, 16'(p));
               wr(2'd0, 16'(c));
               addr = 2'd0;
               en = 1'b1;
               for (int e = 0; e < n; e++) begin
                  bit exp_irq;
                  @(negedge clk);
                  exp_irq = (e >= first) && (((e - first) % gap) == 0);
                  if (irq) hits++;
                  if (irq !== exp_irq && bad == 0) begin
                     ba = irq; be = exp_irq;
                  end
                  if (irq !== exp_irq) bad++;
               end
               en = 1'b0;
               chk(bad == 0, (p == 0) ? "R7 irq timing period zero" :
                              (s == 0) ? "R6 irq timing" : "R3 irq timing prescaled",
                   ba, be);
               chk(hits == 3, "R5 pulse count", hits, 3);
            end
         end
      end

      // R8 hold with scale 0
      do_reset();
      wr(2'd1, 16'd3);
      wr(2'd0, 16'd10);
      addr = 2'd0;
      en = 1'b1; edges(4); en = 1'b0;
      rd(2'd0, v); chk(v == 6, "R4 count after four ticks", v, 6);
      begin
         int moved = 0;
         for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            rd(2'd0, v);
            if (v != 6 || irq) moved++;
         end
         chk(moved == 0, "R8 frozen while disabled", moved, 0);
      end
      en = 1'b1; edges(6);
      rd(2'd0, v); chk(v == 0, "R8 resume to zero", v, 0);
      chk(irq == 1'b0, "R5 no irq before expiry", irq, 0);
      edges(1);
      chk(irq == 1'b1, "R5 irq on expiry", irq, 1);
      rd(2'd0, v); chk(v == 3, "R5 reload from period", v, 3);
      edges(1);
      chk(irq == 1'b0, "R5 single cycle pulse", irq, 0);
      rd(2'd0, v); chk(v == 2, "R4 decrement after reload", v, 2);
      en = 1'b0;

      // R8 prescaler hold with scale 2
      do_reset();
      wr(2'd2, 16'd2);
      wr(2'd1, 16'd20);
      wr(2'd0, 16'd10);
      addr = 2'd0;
      en = 1'b1; edges(4); en = 1'b0;
      rd(2'd0, v); chk(v == 8, "R3 two ticks in four edges", v, 8);
      edges(3);
      en = 1'b1; edges(2);
      rd(2'd0, v); chk(v == 8, "R8 prescaler state held", v, 8);
      edges(1);
      rd(2'd0, v); chk(v == 7, "R3 tick after held prescaler", v, 7);

      // R9 write during a tick-free cycle then during run
      wr(2'd0, 16'd9);
      rd(2'd0, v); chk(v == 9, "R9 write while running", v, 9);
      edges(1);
      rd(2'd0, v); chk(v == 9, "R3 no tick mid prescale", v, 9);
      edges(1);
      rd(2'd0, v); chk(v == 8, "R4 tick after write", v, 8);
      // write landing on a tick edge (prescaler at zero now reloaded; wait two)
      edges(2);
      wr(2'd0, 16'd40);
      rd(2'd0, v); chk(v == 40, "R9 write beats tick", v, 40);
      en = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule